// File: doc/BRIEF.md
# Wakeup interrupt polarity normaliser

A bank of interrupt input channels that sits in front of an interrupt controller able to sense only rising edges and active-high levels. Each channel carries an enable bit and a 3-bit trigger-type code. The code decides whether the registered input is inverted, and whether the channel passes a level or emits one-cycle pulses. Falling-edge and active-low sources therefore reach the controller as rising-edge or active-high signals. A dual-edge source produces one pulse for every transition.

Software programs the bank through a word-wide register port. Enable bits are packed 32 to a word. Each channel also has its own configuration word. Rewriting a channel's type can make the normalised signal jump while the pin itself is steady. The block mutes the edge output of that channel for the cycle that follows such a write, and likewise for the cycle that follows the setting of its enable bit. The spurious event therefore never reaches the controller.

Top module: `wake_pol_norm`

## Requirements
- R1: Channel c's enable bit is bit c mod 32 of the word at byte address 0x10 + 4*(c/32). It is writable and reads back. Bits of those words with no channel behind them read 0.
- R2: Channel c's type code lives in bits [2:0] of the word at byte address 0x110 + 4*c. Writes keep only those three bits, and reads return the code zero-extended.
- R3: A channel whose enable bit is 0 drives its output low whatever its input does.
- R4: Code 100 (level, active high): an enabled channel's output equals its input as registered at the last clock edge.
- R5: Code 000 (level, active low): an enabled channel's output is the inverse of its registered input.
- R6: Code 110 (rising edge): a 0-to-1 input change registered at edge k drives the output high from edge k to edge k+1 only. A 1-to-0 change gives no pulse.
- R7: Code 010 (falling edge): a 1-to-0 input change gives the same one-cycle pulse, and a 0-to-1 change gives none.
- R8: Code 111 (dual edge): every registered input change, in either direction, gives a one-cycle pulse.
- R9: Codes 001, 011 and 101 select no mode, and the output stays low.
- R10: After a write to a channel's type word, or a write that sets its enable bit from 0 to 1, that channel's edge output is held low for one cycle. A type change with a steady input never produces a pulse.
- R11: Addresses that are not word aligned, or that hit neither register group, read as zero and ignore writes.
- R12: After reset all enable bits and type codes are zero, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address for read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| irq_i | input | NUM_CH | Synchronous interrupt inputs |
| irq_o | output | NUM_CH | Normalised outputs to the controller |

## Verification
The bench builds the block with NUM_CH = 40. This gives two enable words, and the second word has only eight live bits, so the zero read-back of unbacked bits and the unmapped third word can both be reached. Six adjacent channels carry every type code at once, including an unlisted one, so one input pattern exercises all modes in the same cycle. Writes are issued in the same cycle as input changes, which covers the muting on type and enable writes.

// File: rtl/wpn_pkg.sv
package wpn_pkg;
  localparam int REG_W    = 32;
  localparam int EN_BASE  = 'h010;
  localparam int CFG_BASE = 'h110;

  typedef enum logic [2:0] {
    TRIG_LVL_LO = 3'b000,
    TRIG_FALL   = 3'b010,
    TRIG_LVL_HI = 3'b100,
    TRIG_RISE   = 3'b110,
    TRIG_BOTH   = 3'b111
  } trig_e;

  typedef struct packed {
    logic active;
    logic edge_m;
    logic inv;
    logic both;
  } chan_mode_t;

  function automatic chan_mode_t decode_trig(input logic [2:0] code);
    chan_mode_t m;
    m = '0;
    case (code)
      TRIG_LVL_LO: m = '{active: 1'b1, edge_m: 1'b0, inv: 1'b1, both: 1'b0};
      TRIG_FALL:   m = '{active: 1'b1, edge_m: 1'b1, inv: 1'b1, both: 1'b0};
      TRIG_LVL_HI: m = '{active: 1'b1, edge_m: 1'b0, inv: 1'b0, both: 1'b0};
      TRIG_RISE:   m = '{active: 1'b1, edge_m: 1'b1, inv: 1'b0, both: 1'b0};
      TRIG_BOTH:   m = '{active: 1'b1, edge_m: 1'b1, inv: 1'b0, both: 1'b1};
      default:     m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/wpn_regs.sv
module wpn_regs
  import wpn_pkg::*;
#(
  parameter int NUM_CH = 168,
  parameter int ADDR_W = 12
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [REG_W-1:0]       wdata_i,
  output logic [REG_W-1:0]       rdata_o,
  output logic [NUM_CH-1:0]      en_o,
  output logic [NUM_CH-1:0][2:0] cfg_o,
  output logic [NUM_CH-1:0]      mute_o
);
  localparam int EN_WORDS = (NUM_CH + REG_W - 1) / REG_W;
  localparam int WA_W     = ADDR_W - 2;
  localparam int EN_SEL_W = (EN_WORDS > 1) ? $clog2(EN_WORDS) : 1;
  localparam int CH_SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [WA_W-1:0] EN_LO  = WA_W'(EN_BASE / 4);
  localparam logic [WA_W-1:0] EN_HI  = WA_W'(EN_BASE / 4 + EN_WORDS);
  localparam logic [WA_W-1:0] CFG_LO = WA_W'(CFG_BASE / 4);
  localparam logic [WA_W-1:0] CFG_HI = WA_W'(CFG_BASE / 4 + NUM_CH);

  logic [WA_W-1:0]     widx, en_off, cfg_off;
  logic                aligned, en_hit, cfg_hit;
  logic [EN_SEL_W-1:0] en_sel;
  logic [CH_SEL_W-1:0] cfg_sel;

  assign widx    = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign en_hit  = aligned && (widx >= EN_LO) && (widx < EN_HI);
  assign cfg_hit = aligned && (widx >= CFG_LO) && (widx < CFG_HI);
  assign en_off  = widx - EN_LO;
  assign cfg_off = widx - CFG_LO;
  assign en_sel  = en_off[EN_SEL_W-1:0];
  assign cfg_sel = cfg_off[CH_SEL_W-1:0];

  logic [NUM_CH-1:0]      en_q, mute_q, en_wr_v, cfg_wr_v;
  logic [NUM_CH-1:0][2:0] cfg_q;
  logic [EN_WORDS-1:0][REG_W-1:0] en_words;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    assign en_wr_v[c]  = wr_en_i && en_hit && (en_sel == EN_SEL_W'(c / REG_W));
    assign cfg_wr_v[c] = wr_en_i && cfg_hit && (cfg_sel == CH_SEL_W'(c));
  end

  for (genvar w = 0; w < EN_WORDS; w++) begin : g_word
    for (genvar b = 0; b < REG_W; b++) begin : g_bit
      if (w * REG_W + b < NUM_CH) begin : g_live
        assign en_words[w][b] = en_q[w * REG_W + b];
      end else begin : g_pad
        assign en_words[w][b] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      cfg_q  <= '0;
      mute_q <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        // mute covers the cycle where a new polarity meets old edge history
        mute_q[c] <= cfg_wr_v[c] || (en_wr_v[c] && wdata_i[c % REG_W] && !en_q[c]);
        if (en_wr_v[c])  en_q[c]  <= wdata_i[c % REG_W];
        if (cfg_wr_v[c]) cfg_q[c] <= wdata_i[2:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (en_hit)       rdata_o = en_words[en_sel];
    else if (cfg_hit) rdata_o = {{(REG_W-3){1'b0}}, cfg_q[cfg_sel]};
  end

  assign en_o   = en_q;
  assign cfg_o  = cfg_q;
  assign mute_o = mute_q;
endmodule

// File: rtl/wpn_chan.sv
module wpn_chan
  import wpn_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       irq_i,
  input  logic       en_i,
  input  logic [2:0] cfg_i,
  input  logic       mute_i,
  output logic       sync_o,
  output logic       irq_o
);
  chan_mode_t mode;
  logic sync_q, hist_q, norm, evt;

  assign mode = decode_trig(cfg_i);
  assign norm = sync_q ^ mode.inv;
  assign evt  = mode.both ? (norm ^ hist_q) : (norm & ~hist_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 1'b0;
      hist_q <= 1'b0;
    end else begin
      sync_q <= irq_i;
      hist_q <= norm;
    end
  end

  assign sync_o = sync_q;
  assign irq_o  = en_i && mode.active && (mode.edge_m ? (evt && !mute_i) : norm);
endmodule

// File: rtl/wake_pol_norm.sv
module wake_pol_norm
  import wpn_pkg::*;
#(
  parameter int NUM_CH = 168,
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic [NUM_CH-1:0] irq_i,
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0]      en_q, mute_q, sync_vec;
  logic [NUM_CH-1:0][2:0] cfg_q;

  wpn_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .en_o    (en_q),
    .cfg_o   (cfg_q),
    .mute_o  (mute_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    wpn_chan u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .irq_i  (irq_i[c]),
      .en_i   (en_q[c]),
      .cfg_i  (cfg_q[c]),
      .mute_i (mute_q[c]),
      .sync_o (sync_vec[c]),
      .irq_o  (irq_o[c])
    );
  end
endmodule

// File: rtl/wake_pol_norm_chk.sv
module wake_pol_norm_chk
  import wpn_pkg::*;
#(
  parameter int NUM_CH = 168,
  parameter int ADDR_W = 12
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [ADDR_W-1:0]      addr_i,
  input logic [REG_W-1:0]       rdata_o,
  input logic [NUM_CH-1:0]      irq_o,
  input logic [NUM_CH-1:0]      en_vec,
  input logic [NUM_CH-1:0][2:0] cfg_vec,
  input logic [NUM_CH-1:0]      mute_vec,
  input logic [NUM_CH-1:0]      sync_vec
);
  logic [NUM_CH-1:0] hi_m, lo_m, rise_m, edge_m, bad_m;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_m
    assign hi_m[c]   = (cfg_vec[c] == 3'b100);
    assign lo_m[c]   = (cfg_vec[c] == 3'b000);
    assign rise_m[c] = (cfg_vec[c] == 3'b110);
    assign edge_m[c] = (cfg_vec[c] == 3'b110) || (cfg_vec[c] == 3'b010) || (cfg_vec[c] == 3'b111);
    assign bad_m[c]  = (cfg_vec[c] == 3'b001) || (cfg_vec[c] == 3'b011) || (cfg_vec[c] == 3'b101);
  end

  assert_disabled_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~en_vec) == '0);
  assert_level_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_o ^ sync_vec) & hi_m & en_vec) == '0);
  assert_level_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_o ~^ sync_vec) & lo_m & en_vec) == '0);
  assert_rise_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & $past(irq_o) & rise_m & $past(rise_m)) == '0);
  assert_bad_code_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & bad_m) == '0);
  assert_muted_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & mute_vec & edge_m) == '0);
  assert_unaligned_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[1:0] != 2'b00) |-> (rdata_o == '0));
endmodule

bind wake_pol_norm wake_pol_norm_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .rdata_o  (rdata_o),
  .irq_o    (irq_o),
  .en_vec   (en_q),
  .cfg_vec  (cfg_q),
  .mute_vec (mute_q),
  .sync_vec (sync_vec)
);

// File: tb/tb_wake_pol_norm.sv
module tb_wake_pol_norm;
  localparam int N      = 40;
  localparam int AW     = 12;
  localparam int CLK_PS = 10;
  localparam int WD_CYC = 5000;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [N-1:0]  irq_i = '0;
  logic [N-1:0]  irq_o;
  logic [N-1:0]  irq_v = '0;

  int cyc = 0, checks = 0, errors = 0;

  typedef struct {
    int          due;
    bit          is_rd;
    int          idx;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t q[$];

  wake_pol_norm #(.NUM_CH(N), .ADDR_W(AW)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_i(irq_i), .irq_o(irq_o)
  );

  always #(CLK_PS / 2) clk_i = ~clk_i;

  task automatic drive(input bit w, input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = w;
    addr_i  = a;
    wdata_i = d;
    irq_i   = irq_v;
  endtask

  task automatic idle();
    drive(1'b0, '0, '0);
  endtask

  task automatic exp_out(input int ch, input bit v, input int dly, input string r);
    item_t it;
    it = '{due: cyc + dly, is_rd: 1'b0, idx: ch, exp: {31'b0, v}, req: r};
    q.push_back(it);
  endtask

  task automatic exp_rd(input logic [31:0] v, input string r);
    item_t it;
    it = '{due: cyc + 1, is_rd: 1'b1, idx: 0, exp: v, req: r};
    q.push_back(it);
  endtask

  // monitor: samples just after each rising edge
  initial forever begin
    @(posedge clk_i);
    cyc++;
    #1;
    for (int i = 0; i < q.size(); ) begin
      if (q[i].due == cyc) begin
        logic [31:0] act;
        act = q[i].is_rd ? rdata_o : {31'b0, irq_o[q[i].idx]};
        checks++;
        if (act !== q[i].exp) begin
          errors++;
          $display("FAIL %s: ch/rd %0d actual %0h expected %0h", q[i].req, q[i].idx, act, q[i].exp);
        end
        q.delete(i);
      end else begin
        i++;
      end
    end
  end

  initial begin
    repeat (WD_CYC) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R12 reset state
    drive(0, 12'h010, 0); exp_rd(32'h0, "R12");
    exp_out(0, 0, 1, "R12"); exp_out(39, 0, 1, "R12");
    drive(0, 12'h124, 0); exp_rd(32'h0, "R12");

    // R1 partial upper enable word
    drive(1, 12'h014, 32'hFFFF_FFFF);
    drive(0, 12'h014, 0); exp_rd(32'h0000_00FF, "R1");
    drive(1, 12'h014, 32'h0);
    drive(0, 12'h014, 0); exp_rd(32'h0, "R1");

    // R2 type word keeps three bits
    drive(1, 12'h124, 32'hFFFF_FFFE);
    drive(0, 12'h124, 0); exp_rd(32'h6, "R2");

    // R3 disabled channel ignores input
    irq_v[5] = 1'b1; idle(); exp_out(5, 0, 1, "R3");
    irq_v[5] = 1'b0; idle(); exp_out(5, 0, 1, "R3");
    idle();

    // program ch3..8 with every mode
    drive(1, 12'h11C, 32'h4);
    drive(1, 12'h120, 32'h0);
    drive(1, 12'h128, 32'h2);
    drive(1, 12'h12C, 32'h7);
    drive(1, 12'h130, 32'h5);
    drive(1, 12'h010, 32'h0000_01F8);
    idle(); idle();
    exp_out(3, 0, 1, "R4"); exp_out(4, 1, 1, "R5"); exp_out(8, 0, 1, "R9");
    drive(0, 12'h010, 0); exp_rd(32'h1F8, "R1");

    irq_v[8:3] = '1; idle();
    exp_out(3, 1, 1, "R4"); exp_out(4, 0, 1, "R5"); exp_out(5, 1, 1, "R6");
    exp_out(6, 0, 1, "R7"); exp_out(7, 1, 1, "R8"); exp_out(8, 0, 1, "R9");
    exp_out(5, 0, 2, "R6"); exp_out(7, 0, 2, "R8");
    idle(); idle();

    irq_v[8:3] = '0; idle();
    exp_out(3, 0, 1, "R4"); exp_out(4, 1, 1, "R5"); exp_out(5, 0, 1, "R6");
    exp_out(6, 1, 1, "R7"); exp_out(7, 1, 1, "R8"); exp_out(8, 0, 1, "R9");
    exp_out(6, 0, 2, "R7"); exp_out(7, 0, 2, "R8");
    idle(); idle();

    // R10 polarity flip with steady low input: no phantom
    drive(1, 12'h124, 32'h2);
    exp_out(5, 0, 1, "R10"); exp_out(5, 0, 2, "R10");
    idle(); idle();
    irq_v[5] = 1'b1; idle(); exp_out(5, 0, 1, "R7");
    idle();
    irq_v[5] = 1'b0; idle(); exp_out(5, 1, 1, "R7"); exp_out(5, 0, 2, "R7");
    idle(); idle();

    // R10 type write coincides with a real edge
    irq_v[7] = 1'b1; drive(1, 12'h12C, 32'h7); exp_out(7, 0, 1, "R10");
    idle(); idle();
    irq_v[7] = 1'b0; idle(); exp_out(7, 1, 1, "R8");
    idle(); idle();

    // R10 enable set coincides with a real edge
    irq_v[6] = 1'b1; drive(1, 12'h010, 32'h0000_01B8); exp_out(6, 0, 1, "R3");
    idle();
    irq_v[6] = 1'b0; drive(1, 12'h010, 32'h0000_01F8); exp_out(6, 0, 1, "R10");
    idle(); idle();

    // R11 unmapped and misaligned accesses
    drive(0, 12'h011, 0); exp_rd(32'h0, "R11");
    drive(0, 12'h008, 0); exp_rd(32'h0, "R11");
    drive(1, 12'h012, 32'hFFFF_FFFF);
    drive(0, 12'h010, 0); exp_rd(32'h1F8, "R11");
    drive(1, 12'h1B0, 32'h7);
    drive(0, 12'h1B0, 0); exp_rd(32'h0, "R11");
    drive(1, 12'h018, 32'hFFFF_FFFF);
    drive(0, 12'h018, 0); exp_rd(32'h0, "R11");
    drive(0, 12'h014, 0); exp_rd(32'h0, "R11");
    drive(0, 12'h11C, 0); exp_rd(32'h4, "R2");

    repeat (4) idle();
    if (q.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule